// File: doc/BRIEF.md
# Tag Compare Unit with Match Register

This block is the compare path of a synchronous cache tag memory. A compare request is a read of the stored tag at the registered address, with the data outputs kept off so the same data pins can carry the value to compare. On the clock edge that accepts the request, the compare value is captured in the data-input register. In the next cycle the array returns the stored word. An equality comparator then checks it against the captured value.

The match result leaves through a small output stage that follows the same latency choice as read data. In flow-through mode the result is shown in the cycle after the request, with no register in the path. In pipelined mode it passes through a match register and appears one cycle later. When no compare is in flight, or the request came while the unit was not selected, the valid indication is low, so a stale result is never shown. A match-output enable gates the match pin combinationally, with no clock involved.

Top module: `tag_cmp_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `match_valid` and `match_out` are 0.
- R2: The compare value is taken from `cmp_data` on the clock edge where `cmp_req` and `sel` are both high. Changing `cmp_data` after that edge does not alter the result of that compare.
- R3: The result is a hit only when every bit of the stored word equals the captured value. A single differing bit, in any of the `W` positions, gives a miss. `match_out` is never high while `match_valid` is low.
- R4: With `ft_mode` = 1 (flow-through), `match_valid` is high in exactly the cycle after the request edge. The hit is computed from `rd_data` presented in that cycle.
- R5: With `ft_mode` = 0 (pipelined), `match_valid` is high in exactly the second cycle after the request edge. The hit is computed from `rd_data` presented in the first cycle after that edge.
- R6: A cycle with `cmp_req` = 0, or with `sel` = 0, starts no compare. The cycles where its result would appear show `match_valid` = 0 and `match_out` = 0.
- R7: `match_out` = 1 requires `match_oe` = 1. Dropping `match_oe` forces `match_out` to 0 at once, without a clock edge, and leaves `match_valid` unchanged.
- R8: Compares issued on consecutive cycles each produce their own result, in consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_req | input | 1 | Compare request for this cycle |
| sel | input | 1 | Unit selected; a request without it is ignored |
| cmp_data | input | W | Compare value on the data-input pins |
| rd_data | input | W | Stored word returned by the array, one cycle after the request |
| ft_mode | input | 1 | 1 = flow-through result, 0 = pipelined result |
| match_oe | input | 1 | Match-output enable; acts without a clock |
| match_out | output | 1 | High when a valid compare hit and the output is enabled |
| match_valid | output | 1 | A compare result is presented this cycle |

## Verification
A lost or doubled request flag shows at the ports as `match_valid` in the wrong cycle. This appears one cycle after the request in flow-through mode and two cycles after in pipelined mode. A capture register loaded on the wrong edge, or loaded again afterwards, turns a hit into a miss. The bench reveals this by changing `cmp_data` right after every request. A broken comparator bit or a stuck match register shows as a wrong hit in the first result cycle. The bench sweeps a one-bit difference across every position in both modes to catch it.

// File: rtl/tag_cmp_pkg.sv
package tag_cmp_pkg;
  typedef struct packed {
    logic vld;
    logic hit;
  } match_t;

  localparam match_t MATCH_IDLE = '{vld: 1'b0, hit: 1'b0};
endpackage

// File: rtl/tag_cmp_capture.sv
module tag_cmp_capture #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_req,
  input  logic         sel,
  input  logic [W-1:0] cmp_data,
  output logic         req_q,
  output logic [W-1:0] cmp_q
);
  logic take;
  assign take = cmp_req & sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      req_q <= take;
      if (take) cmp_q <= cmp_data;
    end
  end
endmodule

// File: rtl/tag_cmp_eq.sv
module tag_cmp_eq #(
  parameter int W = 18
) (
  input  logic         req_q,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] cmp_q,
  output tag_cmp_pkg::match_t res
);
  logic [W-1:0] diff;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign diff[b] = stored[b] ^ cmp_q[b];
  end

  always_comb begin
    res.vld = req_q;
    res.hit = req_q & ~|diff;
  end
endmodule

// File: rtl/tag_cmp_outstage.sv
module tag_cmp_outstage (
  input  logic                clk,
  input  logic                rst,
  input  logic                ft_mode,
  input  tag_cmp_pkg::match_t res_d,
  output tag_cmp_pkg::match_t res_out
);
  tag_cmp_pkg::match_t res_q;

  always_ff @(posedge clk) begin
    if (rst) res_q <= tag_cmp_pkg::MATCH_IDLE;
    else     res_q <= res_d;
  end

  assign res_out = ft_mode ? res_d : res_q;
endmodule

// File: rtl/tag_cmp_unit.sv
module tag_cmp_unit #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_req,
  input  logic         sel,
  input  logic [W-1:0] cmp_data,
  input  logic [W-1:0] rd_data,
  input  logic         ft_mode,
  input  logic         match_oe,
  output logic         match_out,
  output logic         match_valid
);
  logic                req_q;
  logic [W-1:0]        cmp_q;
  tag_cmp_pkg::match_t res_d;
  tag_cmp_pkg::match_t res_o;

  tag_cmp_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .cmp_req(cmp_req), .sel(sel),
    .cmp_data(cmp_data), .req_q(req_q), .cmp_q(cmp_q)
  );

  tag_cmp_eq #(.W(W)) u_eq (
    .req_q(req_q), .stored(rd_data), .cmp_q(cmp_q), .res(res_d)
  );

  tag_cmp_outstage u_out (
    .clk(clk), .rst(rst), .ft_mode(ft_mode), .res_d(res_d), .res_out(res_o)
  );

  assign match_valid = res_o.vld;
  assign match_out   = match_oe & res_o.vld & res_o.hit;
endmodule

// File: rtl/tag_cmp_unit_chk.sv
module tag_cmp_unit_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         cmp_req,
  input logic         sel,
  input logic [W-1:0] cmp_data,
  input logic [W-1:0] rd_data,
  input logic         ft_mode,
  input logic         match_oe,
  input logic         match_out,
  input logic         match_valid
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !match_valid && !match_out);

  // R3
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    match_out |-> match_valid);

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !match_oe |-> !match_out);

  // R4
  ft_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && ft_mode) |-> (match_valid == $past(cmp_req && sel)));

  // R5
  pipe_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && !ft_mode) |-> (match_valid == $past(cmp_req && sel, 2)));

  // R2
  ft_value_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && ft_mode && match_valid && match_oe)
      |-> (match_out == (rd_data == $past(cmp_data))));
endmodule

bind tag_cmp_unit tag_cmp_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cmp_req(cmp_req), .sel(sel), .cmp_data(cmp_data),
  .rd_data(rd_data), .ft_mode(ft_mode), .match_oe(match_oe),
  .match_out(match_out), .match_valid(match_valid)
);

// File: tb/tag_cmp_unit_bench.sv
module tag_cmp_unit_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic         cmp_req, sel, ft_mode, match_oe;
  logic [W-1:0] cmp_data, rd_data;
  logic         match_out, match_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tag_cmp_unit #(.W(W)) u_tag_cmp_unit (
    .clk(clk), .rst(rst), .cmp_req(cmp_req), .sel(sel), .cmp_data(cmp_data),
    .rd_data(rd_data), .ft_mode(ft_mode), .match_oe(match_oe),
    .match_out(match_out), .match_valid(match_valid)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Issue one compare and check both result cycles.
  task automatic compare(input string req, input logic ft, input logic s,
                         input logic [W-1:0] stored, input logic [W-1:0] cval,
                         input logic oe);
    logic hit;
    hit = s && (stored == cval);
    @(negedge clk);
    ft_mode = ft; match_oe = oe; sel = s; cmp_req = 1'b1; cmp_data = cval;
    @(negedge clk);
    cmp_req = 1'b0; sel = 1'b1; cmp_data = ~cval; rd_data = stored;
    #1;
    check({req, " cycle+1 valid"}, match_valid, ft && s);
    check({req, " cycle+1 match"}, match_out, ft && oe && hit);
    @(negedge clk);
    rd_data = ~stored;
    #1;
    check({req, " cycle+2 valid"}, match_valid, !ft && s);
    check({req, " cycle+2 match"}, match_out, !ft && oe && hit);
  endtask

  initial begin
    rst = 1'b1; cmp_req = 1'b0; sel = 1'b1; ft_mode = 1'b1; match_oe = 1'b1;
    cmp_data = '0; rd_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", match_valid, 1'b0);
    check("R1 reset match", match_out, 1'b0);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 after reset valid", match_valid, 1'b0);

    for (int m = 0; m < 2; m++) begin
      logic [W-1:0] base;
      base = 18'h2A5C3 ^ (m * 18'h1111);
      compare("R2 R3 equal", m[0], 1'b1, base, base, 1'b1);
      for (int b = 0; b < W; b++) begin
        compare(m ? "R4 R3 one-bit diff" : "R5 R3 one-bit diff",
                m[0], 1'b1, base, base ^ (18'd1 << b), 1'b1);
      end
      compare("R3 all ones", m[0], 1'b1, '1, '1, 1'b1);
      compare("R3 zero", m[0], 1'b1, '0, '0, 1'b1);
      compare("R6 deselected", m[0], 1'b0, base, base, 1'b1);
      compare("R7 oe low", m[0], 1'b1, base, base, 1'b0);
    end

    // R6: idle cycles present nothing.
    repeat (3) begin
      @(negedge clk); #1;
      check("R6 idle valid", match_valid, 1'b0);
      check("R6 idle match", match_out, 1'b0);
    end

    // R7: asynchronous gating in flow-through.
    @(negedge clk);
    ft_mode = 1'b1; match_oe = 1'b1; cmp_req = 1'b1; cmp_data = 18'h15555;
    @(negedge clk);
    cmp_req = 1'b0; rd_data = 18'h15555;
    #1;
    check("R7 oe high match", match_out, 1'b1);
    match_oe = 1'b0; #1;
    check("R7 oe dropped match", match_out, 1'b0);
    check("R7 oe dropped valid", match_valid, 1'b1);
    match_oe = 1'b1; #1;
    check("R7 oe restored match", match_out, 1'b1);

    // R8: back-to-back pipelined compares, hit then miss then hit.
    @(negedge clk);
    ft_mode = 1'b0; cmp_req = 1'b1; cmp_data = 18'h00F0F;
    @(negedge clk);
    rd_data = 18'h00F0F; cmp_data = 18'h3C3C3;
    @(negedge clk);
    rd_data = 18'h3C3C2; cmp_data = 18'h12345;
    #1;
    check("R8 first valid", match_valid, 1'b1);
    check("R8 first hit", match_out, 1'b1);
    @(negedge clk);
    cmp_req = 1'b0; rd_data = 18'h12345;
    #1;
    check("R8 second valid", match_valid, 1'b1);
    check("R8 second miss", match_out, 1'b0);
    @(negedge clk);
    rd_data = '0;
    #1;
    check("R8 third valid", match_valid, 1'b1);
    check("R8 third hit", match_out, 1'b1);
    @(negedge clk); #1;
    check("R8 drained valid", match_valid, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule